// File: doc/BRIEF.md
# Two-Stage Oversampling DAC Sequencer

This block turns a 12-bit two's complement actuator command into two streams for a mixed-resolution converter. The upper eight bits, sign included, drive a coarse 8-bit DAC code. The lower four bits leave one at a time, starting with the most significant, on a 1-bit fine DAC line. When the analog stage sums the coarse code with the fine stream over a whole sequence, the average carries all twelve bits.

A clock-enable strobe marks each coarse update tick. Every fine bit is held for a fixed number of ticks, four by default. A full sequence therefore lasts sixteen ticks, and a one-clock marker flags the start of each sequence. Software-style writes can arrive at any time. They land in a shadow register and take effect only at the next sequence boundary, so a sequence never mixes bits from two different words. A per-write resolution select clears the low bits for channels with less than 12 bits of resolution. Such channels are expected to send their data already left-justified.

Top module: `osdac_seq`

## Requirements
- R1: After synchronous reset, coarse_o is 0, fine_o is 0 and seq_start_o is 0. The shadow word is cleared, so the first sequence after reset plays out the value 0 unless a write arrives before the first tick.
- R2: coarse_o, fine_o and seq_start_o change only at clock edges where tick_i is 1, except that seq_start_o falls on the clock after it rose.
- R3: At every tick, coarse_o is loaded with bits [11:4] of the word in effect, with the two's complement bits copied unchanged.
- R4: Within a sequence, fine_o carries bit 3 of the word in effect, then bit 2, then bit 1, then bit 0. Each bit is held for TICKS_PER_BIT ticks (4 by default).
- R5: A sequence lasts 4 × TICKS_PER_BIT ticks, and the first sequence begins with the first tick after reset. seq_start_o is 1 for exactly the one clock after the tick that opens a sequence, and is 0 at all other times.
- R6: A write accepted during a sequence does not change the coarse or fine output for the rest of that sequence. The written word becomes the word in effect from the next sequence on.
- R7: When several writes arrive before one sequence boundary, only the last one takes effect.
- R8: With res_mode_i = 2'b10 or 2'b11 (8-bit channel), bits [3:0] of the written word are forced to zero.
- R9: With res_mode_i = 2'b01 (10-bit channel), bits [1:0] are forced to zero. With 2'b00 (12-bit channel), the word is kept as written.
- R10: res_mode_i is sampled only in the clock where wr_en_i is 1. Changing it later does not alter a word that has already been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Coarse-rate clock enable, one clock wide per tick |
| wr_en_i | input | 1 | Write strobe for wr_data_i |
| wr_data_i | input | 12 | Two's complement command word |
| res_mode_i | input | 2 | Channel resolution: 00 = 12-bit, 01 = 10-bit, 1x = 8-bit |
| coarse_o | output | 8 | Coarse DAC code, bits [11:4] of the word in effect |
| fine_o | output | 1 | Serial fine DAC bit |
| seq_start_o | output | 1 | One-clock marker at the start of each sequence |

## Verification
The bench sweeps every 12-bit code in 12-bit mode and a strided set of codes in each of the other modes. During every sequence it writes the next word mid-sequence. A design that copied the shadow straight into the output path would show a torn sequence whose later fine bits come from the new word. A design that sent the fine bits LSB-first, or held each one for the wrong number of ticks, would miscompare on almost every code. Separate runs with idle clocks between ticks check that nothing moves without a tick. Other runs check that only the last of two writes survives, and that changing the resolution select after a write leaves the stored word unmasked differently. A design that latched the mode at load time instead of at write time would clear the wrong low bits.

// File: rtl/osdac_pkg.sv
package osdac_pkg;

    localparam int WORD_W   = 12;
    localparam int COARSE_W = 8;
    localparam int FINE_W   = WORD_W - COARSE_W;
    localparam int MID_W    = 2;   // bits cleared for 10-bit channels

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        RES_12  = 2'b00,
        RES_10  = 2'b01,
        RES_8   = 2'b10,
        RES_8_B = 2'b11
    } res_e;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } split_t;

    function automatic word_t apply_res(word_t w, res_e m);
        word_t r;
        r = w;
        case (m)
            RES_12:  r = w;
            RES_10:  r[MID_W-1:0] = '0;
            default: r[FINE_W-1:0] = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/osdac_shadow.sv
module osdac_shadow
    import osdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en_i,
    input  word_t      wr_data_i,
    input  logic [1:0] res_mode_i,
    output word_t      shadow_o
);

    word_t shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (wr_en_i) begin
            shadow_q <= apply_res(wr_data_i, res_e'(res_mode_i));
        end
    end

    assign shadow_o = shadow_q;

    // R8: an 8-bit channel write leaves no low nibble behind
    a_r8_low_nibble_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && res_mode_i[1]) |=> (shadow_q[FINE_W-1:0] == '0));

    // R10: the shadow only moves on a write
    a_r10_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(shadow_q));

endmodule

// File: rtl/osdac_phase.sv
module osdac_phase
    import osdac_pkg::*;
#(
    parameter int TICKS_PER_BIT = 4,
    localparam int SEQ_TICKS = FINE_W * TICKS_PER_BIT,
    localparam int PH_W      = $clog2(SEQ_TICKS),
    localparam int SUB_W     = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
    localparam int IDX_W     = $clog2(FINE_W)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output logic             seq_begin_o,
    output logic             bit_first_o,
    output logic [IDX_W-1:0] bit_idx_o
);

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SEQ_TICKS - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

    logic [SUB_W-1:0] sub_q;
    logic [IDX_W-1:0] idx_q;
    logic [PH_W-1:0]  ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            idx_q <= '0;
            ph_q  <= '0;
        end else if (tick_i) begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                idx_q <= idx_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign seq_begin_o = (sub_q == '0) && (idx_q == '0);
    assign bit_first_o = (sub_q == '0);
    assign bit_idx_o   = idx_q;

    // R5: the sequence counter wraps back to its start after the last tick
    a_r5_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ph_q == PH_LAST) |=> seq_begin_o);

    // R5: the two views of the position agree
    a_r5_phase_agree: assert property (@(posedge clk) disable iff (rst)
        seq_begin_o == (ph_q == '0));

endmodule

// File: rtl/osdac_serializer.sv
module osdac_serializer
    import osdac_pkg::*;
#(
    localparam int IDX_W = $clog2(FINE_W)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                seq_begin_i,
    input  logic                bit_first_i,
    input  logic [IDX_W-1:0]    bit_idx_i,
    input  word_t               shadow_i,
    output logic [COARSE_W-1:0] coarse_o,
    output logic                fine_o,
    output logic                seq_start_o
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(FINE_W - 1);

    word_t            active_q;
    word_t            cur_w;
    split_t           cur_s;
    logic [IDX_W-1:0] sel;

    always_comb begin
        cur_w = seq_begin_i ? shadow_i : active_q;
        cur_s = split_t'(cur_w);
        sel   = IDX_TOP - bit_idx_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= '0;
            coarse_o    <= '0;
            fine_o      <= 1'b0;
            seq_start_o <= 1'b0;
        end else begin
            seq_start_o <= 1'b0;
            if (tick_i) begin
                if (seq_begin_i) begin
                    active_q <= shadow_i;
                end
                coarse_o    <= cur_s.coarse;
                fine_o      <= cur_s.fine[sel];
                seq_start_o <= seq_begin_i;
            end
        end
    end

    // R2: no tick, no output movement
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(coarse_o) && $stable(fine_o)));

    // R4: a fine bit holds across the ticks of its period
    a_r4_fine_hold: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !bit_first_i) |=> $stable(fine_o));

    // R6: the word in effect only changes at a sequence boundary
    a_r6_active_hold: assert property (@(posedge clk) disable iff (rst)
        !(tick_i && seq_begin_i) |=> $stable(active_q));

    // R5: the start marker lasts a single clock
    a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
        seq_start_o |=> !seq_start_o);

endmodule

// File: rtl/osdac_seq.sv
module osdac_seq
    import osdac_pkg::*;
#(
    parameter int TICKS_PER_BIT = 4
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [11:0] wr_data_i,
    input  logic [1:0]  res_mode_i,
    output logic [7:0]  coarse_o,
    output logic        fine_o,
    output logic        seq_start_o
);

    localparam int IDX_W = $clog2(FINE_W);

    word_t            shadow_w;
    logic             seq_begin;
    logic             bit_first;
    logic [IDX_W-1:0] bit_idx;

    osdac_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .res_mode_i (res_mode_i),
        .shadow_o   (shadow_w)
    );

    osdac_phase #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .seq_begin_o (seq_begin),
        .bit_first_o (bit_first),
        .bit_idx_o   (bit_idx)
    );

    osdac_serializer u_ser (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .seq_begin_i (seq_begin),
        .bit_first_i (bit_first),
        .bit_idx_i   (bit_idx),
        .shadow_i    (shadow_w),
        .coarse_o    (coarse_o),
        .fine_o      (fine_o),
        .seq_start_o (seq_start_o)
    );

    // R1: outputs are cleared on the clock after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (coarse_o == '0 && !fine_o && !seq_start_o));

    // R5: a start marker only follows a tick
    a_r5_start_after_tick: assert property (@(posedge clk) disable iff (rst)
        seq_start_o |-> $past(tick_i));

endmodule

// File: tb/osdac_seq_tb_top.sv
module osdac_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_i;
    logic        wr_en_i;
    logic [11:0] wr_data_i;
    logic [1:0]  res_mode_i;
    logic [7:0]  coarse_o;
    logic        fine_o;
    logic        seq_start_o;

    int  n_vec  = 0;
    int  n_err  = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    osdac_seq #(.TICKS_PER_BIT(4)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .res_mode_i  (res_mode_i),
        .coarse_o    (coarse_o),
        .fine_o      (fine_o),
        .seq_start_o (seq_start_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            if (n_err <= 25)
                $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] masked(input logic [11:0] w, input logic [1:0] m);
        if (m == 2'b00)      return w;
        else if (m == 2'b01) return w & 12'hFFC;
        else                 return w & 12'hFF0;
    endfunction

    // One 16-tick sequence; optional writes at tick ka and kb; gap idle clocks after each tick
    task automatic run_seq(input logic [11:0] exp, input int gap,
                           input bit wa, input logic [11:0] da, input logic [1:0] ma, input int ka,
                           input bit wb, input logic [11:0] db, input logic [1:0] mb, input int kb);
        for (int k = 0; k < 16; k++) begin
            tick_i = 1'b1;
            if (wa && k == ka) begin wr_en_i = 1'b1; wr_data_i = da; res_mode_i = ma; end
            if (wb && k == kb) begin wr_en_i = 1'b1; wr_data_i = db; res_mode_i = mb; end
            @(posedge clk);
            @(negedge clk);
            tick_i  = 1'b0;
            wr_en_i = 1'b0;
            check("R3 coarse", coarse_o, exp[11:4]);
            check("R4 fine", fine_o, exp[3 - k/4]);
            check("R5 start", seq_start_o, (k == 0));
            for (int g = 0; g < gap; g++) begin
                @(posedge clk);
                @(negedge clk);
                check("R2 coarse hold", coarse_o, exp[11:4]);
                check("R2 fine hold", fine_o, exp[3 - k/4]);
                check("R2 start low", seq_start_o, 0);
            end
        end
    endtask

    initial begin
        logic [11:0] prev;
        logic [11:0] w;
        rst = 1'b1; tick_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0; res_mode_i = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state, held while no tick arrives
        for (int i = 0; i < 3; i++) begin
            check("R1 coarse", coarse_o, 0);
            check("R1 fine", fine_o, 0);
            check("R1 start", seq_start_o, 0);
            @(posedge clk);
            @(negedge clk);
        end
        // R1 shadow cleared; R6 mid-sequence write; R2 idle clocks between ticks
        run_seq(12'h000, 2, 1'b1, 12'h9A5, 2'b00, 6, 1'b0, 12'h0, 2'b00, 0);
        // R6 word applied next; R7 last of two writes wins; R8 8-bit masking
        run_seq(12'h9A5, 3, 1'b1, 12'h3C7, 2'b10, 3, 1'b1, 12'h5EB, 2'b11, 9);
        // R8 mask of last write; R10 write with 10-bit mode, then change the select
        run_seq(12'h5E0, 0, 1'b1, 12'h7FF, 2'b01, 4, 1'b0, 12'h0, 2'b00, 0);
        res_mode_i = 2'b00;
        // R10 / R9: 10-bit masking kept although the select moved to 12-bit
        run_seq(12'h7FC, 0, 1'b1, 12'h000, 2'b00, 6, 1'b0, 12'h0, 2'b00, 0);
        prev = 12'h000;
        // R3 R4 R9: every code in 12-bit mode
        for (int i = 1; i <= 4096; i++) begin
            w = 12'(i);
            run_seq(prev, 0, 1'b1, w, 2'b00, 6, 1'b0, 12'h0, 2'b00, 0);
            prev = w;
        end
        // R8 R9: strided codes in the reduced modes
        for (int m = 1; m < 4; m++) begin
            for (int i = 0; i < 512; i++) begin
                w = 12'(i * 8 + (i % 8));
                run_seq(prev, 0, 1'b1, w, 2'(m), 6, 1'b0, 12'h0, 2'b00, 0);
                prev = masked(w, 2'(m));
            end
        end
        run_seq(prev, 1, 1'b0, 12'h0, 2'b00, 0, 1'b0, 12'h0, 2'b00, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule